// File: doc/BRIEF.md
# Serial Transceiver with Bus Collision Monitor

This block is an asynchronous serial transmitter and receiver. It sends and receives frames made of a low start bit, eight payload bits with the least significant bit first, an even parity bit and one high stop bit. A programmable divider produces a 16x oversampling tick, and each bit lasts 16 of those ticks. Software writes one byte into a single-entry transmit holding buffer. Received bytes are placed in a receive buffer that carries a valid flag together with parity and framing error flags.

The block has two independent inversion layers. The payload inversion control complements only the eight data bits. It is applied when a byte is written into the transmit buffer and again when the receive buffer is read, so the start, parity and stop bits are unaffected. The line polarity control inverts every level on both pins, including the idle level, the start bit, the parity bit and the stop bit.

During a frame, the transmitter emits one transfer-clock pulse in the middle of each bit. On that pulse the block compares the level it drives with the level it observes on the receive pin. A mismatch sets a sticky bus collision interrupt request. A typical use is a shared single-wire line on which the block hears its own transmission.

Top module: `sio_busguard_uart`

## Requirements
- R1: After reset `txd_o` sits at the idle level (high when `pol_rev`=0, low when `pol_rev`=1), `tx_ready`=1, `rx_valid`=0 and `bc_irq`=0.
- R2: A written byte is sent as 11 bits in this order: start (0), D0 to D7 with the least significant bit first, even parity over D0 to D7, and stop (1). Each bit lasts 16×(`baud_div`+1) clock cycles.
- R3: With `data_inv`=1 at write time, the eight data bits on the line are the complement of `tx_data`. Parity is computed over the data bits as they appear on the line, and the start and stop bits are unchanged.
- R4: `rx_data` equals the stored received byte XOR `data_inv`, evaluated at read time. A `rx_rd` pulse clears `rx_valid` and both error flags.
- R5: With `pol_rev`=1, every level on `txd_o` is inverted, including idle, start, parity and stop. `rxd_i` is interpreted with the same inversion, so a looped-back frame is still received correctly.
- R6: The receiver takes a majority vote of three consecutive 16x samples near mid-bit. A disturbance shorter than one oversampling period inside a bit does not change the received value.
- R7: `rx_par_err` is set with `rx_valid` when the received data bits and parity bit together hold an odd number of ones.
- R8: `rx_frm_err` is set with `rx_valid` when the stop bit is sampled as 0.
- R9: On a `xfer_tick` pulse during transmission, if the driven level differs from the received level, `bc_irq` becomes 1 on the next cycle.
- R10: While no frame is being sent, a mismatch between the pins does not set `bc_irq`.
- R11: `bc_irq` stays 1 until a `bc_clr` pulse clears it.
- R12: `xfer_tick` pulses exactly once per transmitted bit, 11 times per frame, and never twice in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Oversampling tick period minus one, in clock cycles |
| data_inv | input | 1 | Payload inversion select |
| pol_rev | input | 1 | Line polarity reversal select |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DATA_W | Byte to transmit |
| tx_ready | output | 1 | Transmit buffer is empty |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | DATA_W | Received byte after payload inversion |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| rx_par_err | output | 1 | Parity error on the buffered byte |
| rx_frm_err | output | 1 | Stop bit error on the buffered byte |
| txd_o | output | 1 | Serial transmit pin |
| rxd_i | input | 1 | Serial receive pin |
| xfer_tick | output | 1 | Mid-bit transfer-clock pulse during transmission |
| bc_irq | output | 1 | Sticky bus collision interrupt request |
| bc_clr | input | 1 | Clear strobe for `bc_irq` |

## Verification
A corrupted transmit shift register or bit index appears within one bit time as a wrong level on `txd_o` at a mid-bit sample, or as a wrong `xfer_tick` count at the end of the frame. A receiver state fault surfaces at the stop bit as a wrong `rx_data` or a spurious error flag. It appears within one frame because every frame ends in a buffer update. A fault in the collision flag shows as `bc_irq` rising during idle, failing to rise on a forced mismatch, or dropping without `bc_clr`. Each of these is observed within a few hundred cycles of the stimulus that should affect it.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_FRAME = 1'b1
    } sbu_rx_mode_e;

    // majority of three samples
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sbu_baud.sv
module sbu_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: every tick restarts the period count
    p_tick_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/sbu_tx.sv
module sbu_tx #(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              data_inv,
    input  logic              pol_rev,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              busy,
    output logic              line,
    output logic              txd,
    output logic              xfer
);

    localparam int FRAME_BITS = DATA_W + 3;
    localparam int OS_W       = $clog2(OS_RATE);
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OS_RATE - 1);
    localparam logic [OS_W-1:0]  OS_MID   = OS_W'(OS_RATE / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  full;
        logic [DATA_W-1:0]     hold;
        logic                  busy;
        logic [FRAME_BITS-1:0] sh;
        logic [OS_W-1:0]       os;
        logic [IDX_W-1:0]      idx;
    } tx_state_t;

    tx_state_t q, d;

    always_comb begin
        d    = q;
        xfer = 1'b0;
        // holding buffer: payload inversion applied on write
        if (wr && !q.full) begin
            d.full = 1'b1;
            d.hold = wdata ^ {DATA_W{data_inv}};
        end
        if (!q.busy) begin
            if (q.full && os_tick) begin
                d.busy = 1'b1;
                d.full = 1'b0;
                d.sh   = {1'b1, ^q.hold, q.hold, 1'b0};
                d.os   = '0;
                d.idx  = '0;
            end
        end else if (os_tick) begin
            xfer = (q.os == OS_MID);
            if (q.os == OS_LAST) begin
                d.os = '0;
                d.sh = {1'b1, q.sh[FRAME_BITS-1:1]};
                if (q.idx == IDX_LAST) d.busy = 1'b0;
                else                   d.idx  = q.idx + 1'b1;
            end else begin
                d.os = q.os + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line  = q.busy ? q.sh[0] : 1'b1;
    assign txd   = line ^ pol_rev;
    assign ready = !q.full;
    assign busy  = q.busy;

    // R2: first bit of every frame is a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.idx == '0) |-> !line);

    // R2: last bit of every frame is a high stop bit
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.idx == IDX_LAST) |-> line);

    // R12: transfer-clock pulses never come back to back
    p_one_xfer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer);

endmodule

// File: rtl/sbu_rx.sv
module sbu_rx #(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              pol_rev,
    input  logic              data_inv,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              valid,
    output logic              par_err,
    output logic              frm_err,
    output logic              line
);
    import sbu_pkg::*;

    localparam int FRAME_BITS = DATA_W + 3;
    localparam int OS_W       = $clog2(OS_RATE);
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OS_RATE - 1);
    localparam logic [OS_W-1:0]  SMP_A    = OS_W'(OS_RATE / 2 - 2);
    localparam logic [OS_W-1:0]  SMP_B    = OS_W'(OS_RATE / 2 - 1);
    localparam logic [OS_W-1:0]  SMP_C    = OS_W'(OS_RATE / 2);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [1:0]        sync;
        sbu_rx_mode_e      mode;
        logic [OS_W-1:0]   os;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        vote;
        logic [DATA_W:0]   sh;
        logic [DATA_W-1:0] word;
        logic              valid;
        logic              perr;
        logic              ferr;
    } rx_state_t;

    rx_state_t q, d;
    logic      line_c;
    logic      maj;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd};
        line_c = q.sync[1] ^ pol_rev;
        maj    = vote3(q.vote[1], q.vote[0], line_c);
        if (rd) begin
            d.valid = 1'b0;
            d.perr  = 1'b0;
            d.ferr  = 1'b0;
        end
        if (os_tick) begin
            case (q.mode)
                RX_IDLE: begin
                    if (!line_c) begin
                        d.mode = RX_FRAME;
                        d.os   = '0;
                        d.idx  = '0;
                    end
                end
                RX_FRAME: begin
                    if (q.os == SMP_A || q.os == SMP_B)
                        d.vote = {q.vote[0], line_c};
                    if (q.os == SMP_C) begin
                        if (q.idx == '0) begin
                            if (maj) d.mode = RX_IDLE;
                        end else if (q.idx == IDX_LAST) begin
                            d.word  = q.sh[DATA_W-1:0];
                            d.perr  = ^q.sh;
                            d.ferr  = !maj;
                            d.valid = 1'b1;
                            d.mode  = RX_IDLE;
                        end else begin
                            d.sh = {maj, q.sh[DATA_W:1]};
                        end
                    end
                    if (q.os == OS_LAST) begin
                        d.os  = '0;
                        d.idx = q.idx + 1'b1;
                    end else begin
                        d.os = q.os + 1'b1;
                    end
                end
                default: d.mode = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign rdata   = q.word ^ {DATA_W{data_inv}};
    assign valid   = q.valid;
    assign par_err = q.perr;
    assign frm_err = q.ferr;
    assign line    = line_c;

    // R7: an error flag only exists alongside a buffered byte
    p_flags_need_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.perr || q.ferr) |-> q.valid);

    // R4: a read outside a sampling tick empties the buffer
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !os_tick) |=> !q.valid);

endmodule

// File: rtl/sio_busguard_uart.sv
module sio_busguard_uart #(
    parameter int DIV_W   = 16,
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              data_inv,
    input  logic              pol_rev,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              txd_o,
    input  logic              rxd_i,
    output logic              xfer_tick,
    output logic              bc_irq,
    input  logic              bc_clr
);

    logic os_tick;
    logic tx_busy;
    logic tx_line;
    logic rx_line;

    sbu_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (os_tick)
    );

    sbu_tx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .data_inv(data_inv),
        .pol_rev (pol_rev),
        .wr      (tx_wr),
        .wdata   (tx_data),
        .ready   (tx_ready),
        .busy    (tx_busy),
        .line    (tx_line),
        .txd     (txd_o),
        .xfer    (xfer_tick)
    );

    sbu_rx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rxd     (rxd_i),
        .pol_rev (pol_rev),
        .data_inv(data_inv),
        .rd      (rx_rd),
        .rdata   (rx_data),
        .valid   (rx_valid),
        .par_err (rx_par_err),
        .frm_err (rx_frm_err),
        .line    (rx_line)
    );

    // collision flag: set wins over clear
    logic irq_d, irq_q;
    logic clash;

    always_comb begin
        clash = xfer_tick && (tx_line != rx_line);
        irq_d = irq_q;
        if (bc_clr) irq_d = 1'b0;
        if (clash)  irq_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign bc_irq = irq_q;

    // R9: a sampled mismatch raises the request
    p_clash_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_tick && (tx_line != rx_line)) |=> bc_irq);

    // R10: no frame in flight, no new request
    p_idle_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !bc_irq) |=> !bc_irq);

    // R11: request holds until cleared
    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_irq && !bc_clr) |=> bc_irq);

endmodule

// File: tb/sio_busguard_uart_bench.sv
module sio_busguard_uart_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd3;
    logic        data_inv = 1'b0;
    logic        pol_rev = 1'b0;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_ready;
    logic        rx_rd = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_par_err;
    logic        rx_frm_err;
    logic        txd_o;
    logic        rxd_i;
    logic        xfer_tick;
    logic        bc_irq;
    logic        bc_clr = 1'b0;
    logic        loop_en = 1'b1;
    logic        drv = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int xfer_cnt = 0;
    bit finished = 1'b0;

    localparam int BIT_CYC = 64;   // 16 * (baud_div + 1)

    always #2 clk = ~clk;          // 250 MHz

    assign rxd_i = loop_en ? txd_o : drv;

    always @(posedge clk) if (xfer_tick) xfer_cnt <= xfer_cnt + 1;

    sio_busguard_uart u_sio_busguard_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_div  (baud_div),
        .data_inv  (data_inv),
        .pol_rev   (pol_rev),
        .tx_wr     (tx_wr),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_rd     (rx_rd),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err),
        .txd_o     (txd_o),
        .rxd_i     (rxd_i),
        .xfer_tick (xfer_tick),
        .bc_irq    (bc_irq),
        .bc_clr    (bc_clr)
    );

    function automatic logic [10:0] frame_of(input logic [7:0] b);
        return {1'b1, ^b, b, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_pulse();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    // raw mid-bit levels of one transmitted frame
    task automatic grab(input logic rev, output logic [10:0] got);
        int w = 0;
        while (txd_o !== rev && w < 400) begin
            @(negedge clk);
            w++;
        end
        cyc(BIT_CYC / 2);
        for (int k = 0; k < 11; k++) begin
            got[k] = txd_o;
            if (k < 10) cyc(BIT_CYC);
        end
    endtask

    // bench-driven frame on rxd_i (no polarity reversal)
    task automatic send_frame(input logic [7:0] b, input logic bad_par,
                              input logic bad_stop, input int glitch_at);
        logic [10:0] f;
        f = frame_of(b);
        if (bad_par)  f[9]  = ~f[9];
        if (bad_stop) f[10] = 1'b0;
        for (int k = 0; k < 11; k++) begin
            drv = f[k];
            if (k == glitch_at) begin
                cyc(36);
                drv = ~f[k];
                cyc(2);
                drv = f[k];
                cyc(BIT_CYC - 38);
            end else begin
                cyc(BIT_CYC);
            end
        end
        drv = 1'b1;
        cyc(2 * BIT_CYC);
    endtask

    task automatic t_reset();
        chk("R1 idle txd", {31'd0, txd_o}, 32'd1);
        chk("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
        chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        chk("R1 bc_irq", {31'd0, bc_irq}, 32'd0);
    endtask

    task automatic t_plain();
        logic [10:0] got;
        int base;
        base = xfer_cnt;
        write_byte(8'hA5);
        chk("R2 buffer taken", {31'd0, tx_ready}, 32'd0);
        grab(1'b0, got);
        chk("R2 frame bits", {21'd0, got}, {21'd0, frame_of(8'hA5)});
        cyc(48);
        chk("R12 xfer count", xfer_cnt - base, 32'd11);
        chk("R2 loopback data", {24'd0, rx_data}, 32'hA5);
        chk("R2 loopback valid", {31'd0, rx_valid}, 32'd1);
        chk("R7 no parity err", {31'd0, rx_par_err}, 32'd0);
        chk("R8 no frame err", {31'd0, rx_frm_err}, 32'd0);
        chk("R9 no clash on echo", {31'd0, bc_irq}, 32'd0);
        read_pulse();
        chk("R4 read clears valid", {31'd0, rx_valid}, 32'd0);
    endtask

    task automatic t_inv();
        logic [10:0] got;
        data_inv = 1'b1;
        write_byte(8'h3C);
        grab(1'b0, got);
        chk("R3 inverted payload", {21'd0, got}, {21'd0, frame_of(8'hC3)});
        cyc(48);
        data_inv = 1'b0;
        @(negedge clk);
        chk("R4 stored line data", {24'd0, rx_data}, 32'hC3);
        data_inv = 1'b1;
        @(negedge clk);
        chk("R4 inverted on read", {24'd0, rx_data}, 32'h3C);
        read_pulse();
        data_inv = 1'b0;
    endtask

    task automatic t_rev();
        logic [10:0] got;
        pol_rev = 1'b1;
        cyc(4);
        chk("R5 idle reversed", {31'd0, txd_o}, 32'd0);
        write_byte(8'h5A);
        grab(1'b1, got);
        chk("R5 whole frame reversed", {21'd0, got}, {21'd0, ~frame_of(8'h5A)});
        cyc(48);
        chk("R5 reversed receive", {24'd0, rx_data}, 32'h5A);
        chk("R5 no errors", {30'd0, rx_par_err, rx_frm_err}, 32'd0);
        read_pulse();
        pol_rev = 1'b0;
        cyc(8);
        chk("R9 polarity swap no irq", {31'd0, bc_irq}, 32'd0);
    endtask

    task automatic t_glitch();
        loop_en = 1'b0;
        drv = 1'b1;
        cyc(8);
        send_frame(8'h96, 1'b0, 1'b0, 4);
        chk("R6 glitch voted out", {24'd0, rx_data}, 32'h96);
        chk("R6 glitch valid", {31'd0, rx_valid}, 32'd1);
        chk("R6 glitch no err", {30'd0, rx_par_err, rx_frm_err}, 32'd0);
        read_pulse();
    endtask

    task automatic t_errors();
        send_frame(8'h0F, 1'b1, 1'b0, -1);
        chk("R7 parity flagged", {31'd0, rx_par_err}, 32'd1);
        chk("R7 frame ok", {31'd0, rx_frm_err}, 32'd0);
        chk("R7 data kept", {24'd0, rx_data}, 32'h0F);
        read_pulse();
        chk("R7 read clears", {31'd0, rx_par_err}, 32'd0);
        send_frame(8'h81, 1'b0, 1'b1, -1);
        chk("R8 stop flagged", {31'd0, rx_frm_err}, 32'd1);
        chk("R8 parity ok", {31'd0, rx_par_err}, 32'd0);
        chk("R8 valid", {31'd0, rx_valid}, 32'd1);
        read_pulse();
    endtask

    task automatic t_mask();
        drv = 1'b0;
        cyc(500);
        chk("R10 idle mismatch ignored", {31'd0, bc_irq}, 32'd0);
        drv = 1'b1;
        cyc(4 * BIT_CYC);
        if (rx_valid) read_pulse();
    endtask

    task automatic t_clash();
        logic [10:0] got;
        drv = 1'b1;
        write_byte(8'h00);
        grab(1'b0, got);
        cyc(48);
        chk("R9 clash raised", {31'd0, bc_irq}, 32'd1);
        cyc(300);
        chk("R11 stays set", {31'd0, bc_irq}, 32'd1);
        bc_clr = 1'b1;
        @(negedge clk);
        bc_clr = 1'b0;
        @(negedge clk);
        chk("R11 cleared", {31'd0, bc_irq}, 32'd0);
        loop_en = 1'b1;
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(4);
        t_reset();
        t_plain();
        t_inv();
        t_rev();
        t_glitch();
        t_errors();
        t_mask();
        t_clash();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule